// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

The block controls the timing of a multichannel sampling converter. A single-cycle start pulse opens a conversion group. Each conversion has two phases. The first is an acquisition phase, whose length in cycles is programmable. At its end the digitized input of the channel is captured and clipped to the chosen resolution. The second is a conversion phase, whose length in cycles is also programmable. At its end the captured value is committed to that channel's result register, and a one-cycle valid pulse appears together with the channel index. The per-channel sample bus stands in for the analog front end.

Three grouping modes decide which channels a start pulse converts:
- **Round-robin** converts one channel per start.
- **Parallel** captures and commits every active channel at once.
- **Staggered** converts each active channel in turn. The channels are spread at equal offsets over the interval measured between the two most recent accepted start pulses.

A completion event can be raised at the end of either phase, after a programmable delay in cycles. A window watchdog flags any committed value that lies outside a lower and an upper bound. A start pulse that arrives while a group is still running is dropped, and a sticky overrun flag records it.

Top module: `adc_seq`

## Requirements
- R1: After reset, `res_o`, `valid_o`, `valid_ch_o`, `evt_o`, `wd_evt_o` and `overrun_o` are all zero.
- R2: A committed value equals the captured raw sample when the sample is below full scale. Otherwise it equals full scale, which is 4095 when `res16_i`=0 and 65535 when `res16_i`=1.
- R3: Let the cycle in which an accepted `start_i` is high be cycle 0, and let A=`acq_len_i` and C=`conv_len_i`, where a value of 0 counts as 1. The first result's `valid_o` is high in cycle A+C+1. The sample is the value on `samp_i` in cycle A.
- R4: With `mode_i`=0 (round-robin), each accepted start converts one channel, taking 0,1,…,`last_ch_i` in turn and then wrapping to 0. `valid_ch_o` reports that channel, and every other result register keeps its value.
- R5: With `mode_i`=1 (parallel), one accepted start captures all channels 0..`last_ch_i` in the same cycle. All of them are overwritten in the single cycle in which `valid_o` pulses once, with `valid_ch_o`=`last_ch_i`. Channels above `last_ch_i` are untouched.
- R6: With `mode_i`=2 (staggered), channel k (k=0..`last_ch_i`) is launched k·D cycles after the start. D=floor(P/(`last_ch_i`+1)), where P is the number of cycles between the two most recent accepted starts, or 0 if there was no earlier start. Each launch waits until the previous conversion has ended. When D≥A+C+1, channel k is valid in cycle k·D+A+C+1, with `valid_ch_o`=k.
- R7: With `irq_en_i`=1, `evt_o` pulses once per conversion (once per group in parallel mode). When `irq_at_conv_i`=0 it pulses in cycle A+1+L, and when `irq_at_conv_i`=1 in cycle A+C+1+L, where L=`lat_i`. With `irq_en_i`=0 it does not pulse.
- R8: A `start_i` that arrives while a group is still in progress starts nothing, and it sets `overrun_o`. `overrun_o` then stays high until reset.
- R9: With `wd_en_i`=1, `wd_evt_o` pulses in the same cycle as `valid_o` when any value committed in that cycle is below `wd_lo_i` or above `wd_hi_i`. Values equal to either bound do not trigger it. With `wd_en_i`=0 it never pulses.
- R10: `valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a conversion group |
| samp_i | input | NCH*RAW_W | Raw sample per channel; channel i at bits [i*RAW_W +: RAW_W] |
| res16_i | input | 1 | 1: 16-bit resolution, 0: 12-bit resolution |
| last_ch_i | input | CHW | Index of the highest active channel (count minus one) |
| mode_i | input | 2 | 0 round-robin, 1 parallel, 2 staggered (3 behaves as 0) |
| acq_len_i | input | CW | Acquisition length in cycles |
| conv_len_i | input | CW | Conversion length in cycles |
| irq_en_i | input | 1 | Enables the completion event |
| irq_at_conv_i | input | 1 | 0: event after acquisition, 1: event after conversion |
| lat_i | input | CW | Event delay in cycles |
| wd_en_i | input | 1 | Enables the window watchdog |
| wd_lo_i | input | DW | Lower window bound |
| wd_hi_i | input | DW | Upper window bound |
| res_o | output | NCH*DW | Result registers; channel i at bits [i*DW +: DW] |
| valid_o | output | 1 | One-cycle pulse on a commit |
| valid_ch_o | output | CHW | Channel index of the latest commit |
| evt_o | output | 1 | Completion event pulse |
| wd_evt_o | output | 1 | Watchdog event pulse |
| overrun_o | output | 1 | Sticky flag for a dropped start |

## Verification
A wrong phase counter shifts the valid and event pulses by whole cycles, so the first affected conversion exposes it: the bench compares pulse cycles exactly across a sweep of phase lengths and delays. A wrong rotation pointer or channel mask shows at the next commit. The wrong channel index appears, or result registers that should have been left alone change value. A miscomputed stagger offset shows up in the launch times of the second and later channels in the group. Clipping and window errors appear in the very result or watchdog pulse that the bad value produces.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [1:0] {
        M_SEQ = 2'd0,
        M_SIM = 2'd1,
        M_OVS = 2'd2,
        M_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACQ  = 2'd1,
        S_CONV = 2'd2,
        S_WAIT = 2'd3
    } state_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 8,
    parameter int TW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [CHW-1:0] last_ch_i,
    input  logic [1:0]     mode_i,
    input  logic [CW-1:0]  acq_len_i,
    input  logic [CW-1:0]  conv_len_i,
    output logic [NCH-1:0] hold_o,
    output logic [NCH-1:0] wr_o,
    output logic [CHW-1:0] wr_ch_o,
    output logic           trig_acq_o,
    output logic           trig_conv_o,
    output logic           overrun_o
);

    typedef struct packed {
        state_e         st;
        logic [CW-1:0]  cnt;
        mode_e          mode;
        logic [CHW-1:0] last;
        logic [CHW-1:0] ptr;
        logic [CHW-1:0] slot;
        logic [CHW-1:0] ch;
        logic [TW-1:0]  el;
        logic [TW-1:0]  tgt;
        logic [TW-1:0]  dly;
        logic [TW-1:0]  since;
        logic           have_prev;
        logic           ovr;
    } ctrl_t;

    ctrl_t q, d;

    logic [CW-1:0]  acq_ld, conv_ld;
    logic [CHW-1:0] cur, nxt;
    logic [TW-1:0]  per_new, div_n;
    logic [NCH-1:0] mask;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            if (q.mode == M_SIM) mask[i] = (CHW'(i) <= q.last);
            else                 mask[i] = (CHW'(i) == q.ch);
        end
    end

    always_comb begin
        d           = q;
        hold_o      = '0;
        wr_o        = '0;
        trig_acq_o  = 1'b0;
        trig_conv_o = 1'b0;
        acq_ld      = (acq_len_i  == '0) ? '0 : acq_len_i  - 1'b1;
        conv_ld     = (conv_len_i == '0) ? '0 : conv_len_i - 1'b1;
        cur         = (q.ptr > last_ch_i) ? '0 : q.ptr;
        nxt         = (cur >= last_ch_i) ? '0 : cur + 1'b1;
        per_new     = q.have_prev ? q.since : '0;
        div_n       = TW'(last_ch_i) + TW'(1);

        if (q.since != '1) d.since = q.since + 1'b1;
        if (q.st != S_IDLE && q.el != '1) d.el = q.el + 1'b1;

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st        = S_ACQ;
                    d.cnt       = acq_ld;
                    d.mode      = mode_e'(mode_i);
                    d.last      = last_ch_i;
                    d.el        = TW'(1);
                    d.since     = TW'(1);
                    d.have_prev = 1'b1;
                    d.slot      = '0;
                    d.tgt       = '0;
                    d.dly       = per_new / div_n;
                    if (mode_e'(mode_i) == M_SIM || mode_e'(mode_i) == M_OVS) begin
                        d.ch = '0;
                    end else begin
                        d.ch  = cur;
                        d.ptr = nxt;
                    end
                end
            end
            S_ACQ: begin
                if (q.cnt == '0) begin
                    trig_acq_o = 1'b1;
                    hold_o     = mask;
                    d.st       = S_CONV;
                    d.cnt      = conv_ld;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_CONV: begin
                if (q.cnt == '0) begin
                    trig_conv_o = 1'b1;
                    wr_o        = mask;
                    if (q.mode == M_OVS && q.slot < q.last) begin
                        d.st   = S_WAIT;
                        d.slot = q.slot + 1'b1;
                        d.tgt  = q.tgt + q.dly;
                    end else begin
                        d.st = S_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_WAIT: begin
                if (q.el >= q.tgt) begin
                    d.st  = S_ACQ;
                    d.cnt = acq_ld;
                    d.ch  = q.slot;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (start_i && q.st != S_IDLE) d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ch_o   = (q.mode == M_SIM) ? q.last : q.ch;
    assign overrun_o = q.ovr;

endmodule

// File: rtl/adc_seq_bank.sv
`timescale 1ns/1ps
module adc_seq_bank #(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int NARROW_W = 12,
    parameter int RAW_W    = 17,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH*RAW_W-1:0] samp_i,
    input  logic               res16_i,
    input  logic [NCH-1:0]     hold_i,
    input  logic [NCH-1:0]     wr_i,
    input  logic [CHW-1:0]     wr_ch_i,
    input  logic               wd_en_i,
    input  logic [DW-1:0]      wd_lo_i,
    input  logic [DW-1:0]      wd_hi_i,
    output logic [NCH*DW-1:0]  res_o,
    output logic               valid_o,
    output logic [CHW-1:0]     valid_ch_o,
    output logic               wd_o
);

    localparam logic [DW-1:0] FULL_WIDE   = {DW{1'b1}};
    localparam logic [DW-1:0] FULL_NARROW = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] hold;
        logic [NCH-1:0][DW-1:0] res;
        logic                   valid;
        logic [CHW-1:0]         ch;
        logic                   wd;
    } bank_t;

    bank_t q, d;

    logic [DW-1:0]          full;
    logic [NCH-1:0][DW-1:0] sat_w;

    assign full = res16_i ? FULL_WIDE : FULL_NARROW;

    for (genvar g = 0; g < NCH; g++) begin : g_sat
        logic [RAW_W-1:0] raw;
        assign raw      = samp_i[g*RAW_W +: RAW_W];
        assign sat_w[g] = (raw > RAW_W'(full)) ? full : raw[DW-1:0];
    end

    always_comb begin
        d       = q;
        d.valid = |wr_i;
        d.wd    = 1'b0;
        if (|wr_i) d.ch = wr_ch_i;
        for (int i = 0; i < NCH; i++) begin
            if (hold_i[i]) d.hold[i] = sat_w[i];
            if (wr_i[i]) begin
                d.res[i] = q.hold[i];
                if (wd_en_i && (q.hold[i] < wd_lo_i || q.hold[i] > wd_hi_i)) d.wd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_o      = q.res;
    assign valid_o    = q.valid;
    assign valid_ch_o = q.ch;
    assign wd_o       = q.wd;

endmodule

// File: rtl/adc_seq_evt.sv
`timescale 1ns/1ps
module adc_seq_evt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [CW-1:0] lat_i,
    output logic          evt_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          evt;
    } evt_t;

    evt_t q, d;

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) d.evt = 1'b1;
        end
        if (trig_i) begin
            if (lat_i == '0) d.evt = 1'b1;
            else             d.cnt = lat_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt_o = q.evt;

endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int NARROW_W = 12,
    parameter int RAW_W    = 17,
    parameter int CW       = 8,
    parameter int TW       = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NCH*RAW_W-1:0] samp_i,
    input  logic                 res16_i,
    input  logic [CHW-1:0]       last_ch_i,
    input  logic [1:0]           mode_i,
    input  logic [CW-1:0]        acq_len_i,
    input  logic [CW-1:0]        conv_len_i,
    input  logic                 irq_en_i,
    input  logic                 irq_at_conv_i,
    input  logic [CW-1:0]        lat_i,
    input  logic                 wd_en_i,
    input  logic [DW-1:0]        wd_lo_i,
    input  logic [DW-1:0]        wd_hi_i,
    output logic [NCH*DW-1:0]    res_o,
    output logic                 valid_o,
    output logic [CHW-1:0]       valid_ch_o,
    output logic                 evt_o,
    output logic                 wd_evt_o,
    output logic                 overrun_o
);

    logic [NCH-1:0] hold, wr;
    logic [CHW-1:0] wr_ch;
    logic           trig_acq, trig_conv, evt_trig;

    adc_seq_ctrl #(.NCH(NCH), .CW(CW), .TW(TW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .last_ch_i   (last_ch_i),
        .mode_i      (mode_i),
        .acq_len_i   (acq_len_i),
        .conv_len_i  (conv_len_i),
        .hold_o      (hold),
        .wr_o        (wr),
        .wr_ch_o     (wr_ch),
        .trig_acq_o  (trig_acq),
        .trig_conv_o (trig_conv),
        .overrun_o   (overrun_o)
    );

    adc_seq_bank #(.NCH(NCH), .DW(DW), .NARROW_W(NARROW_W), .RAW_W(RAW_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_i     (samp_i),
        .res16_i    (res16_i),
        .hold_i     (hold),
        .wr_i       (wr),
        .wr_ch_i    (wr_ch),
        .wd_en_i    (wd_en_i),
        .wd_lo_i    (wd_lo_i),
        .wd_hi_i    (wd_hi_i),
        .res_o      (res_o),
        .valid_o    (valid_o),
        .valid_ch_o (valid_ch_o),
        .wd_o       (wd_evt_o)
    );

    assign evt_trig = irq_en_i & (irq_at_conv_i ? trig_conv : trig_acq);

    adc_seq_evt #(.CW(CW)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (evt_trig),
        .lat_i  (lat_i),
        .evt_o  (evt_o)
    );

endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
    parameter int RW = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          valid_o,
    input logic          wd_evt_o,
    input logic          overrun_o,
    input logic [RW-1:0] res_o
);

    // R10
    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R8
    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(start_i));

    // R9
    a_r9_wd_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wd_evt_o |-> valid_o);

    // R4
    a_r4_res_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_o) |-> valid_o);

endmodule

bind adc_seq adc_seq_chk #(.RW(NCH*DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .valid_o   (valid_o),
    .wd_evt_o  (wd_evt_o),
    .overrun_o (overrun_o),
    .res_o     (res_o)
);

// File: tb/test_adc_seq.sv
`timescale 1ns/1ps
module test_adc_seq;

    localparam int NCH = 16, DW = 16, RAW_W = 17, CW = 8, CHW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NCH*RAW_W-1:0] samp = '0;
    logic               res16 = 1'b0;
    logic [CHW-1:0]     last_ch = '0;
    logic [1:0]         mode = 2'd0;
    logic [CW-1:0]      acq_len = 8'd2, conv_len = 8'd2, lat = 8'd0;
    logic               irq_en = 1'b1, irq_at_conv = 1'b1, wd_en = 1'b0;
    logic [DW-1:0]      wd_lo = 16'd0, wd_hi = 16'hFFFF;
    logic [NCH*DW-1:0]  res;
    logic               valid, evt, wd_evt, overrun;
    logic [CHW-1:0]     valid_ch;

    adc_seq i_adc_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .samp_i(samp), .res16_i(res16),
        .last_ch_i(last_ch), .mode_i(mode), .acq_len_i(acq_len), .conv_len_i(conv_len),
        .irq_en_i(irq_en), .irq_at_conv_i(irq_at_conv), .lat_i(lat), .wd_en_i(wd_en),
        .wd_lo_i(wd_lo), .wd_hi_i(wd_hi), .res_o(res), .valid_o(valid),
        .valid_ch_o(valid_ch), .evt_o(evt), .wd_evt_o(wd_evt), .overrun_o(overrun)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int vn = 0, en = 0, wn = 0, t0 = 0;
    int vcyc[32], vch[32], ecyc[32], wcyc[32];

    always @(negedge clk) begin
        if (valid  && vn < 32) begin vcyc[vn] = cyc; vch[vn] = int'(valid_ch); vn++; end
        if (evt    && en < 32) begin ecyc[en] = cyc; en++; end
        if (wd_evt && wn < 32) begin wcyc[wn] = cyc; wn++; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        vn = 0; en = 0; wn = 0;
    endtask

    task automatic set_samp(input int ch, input int v);
        samp[ch*RAW_W +: RAW_W] = RAW_W'(v);
    endtask

    function automatic int get_res(input int ch);
        return int'(res[ch*DW +: DW]);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        report();
        $finish;
    end

    initial begin
        int s;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 res", int'(res != '0), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 valid_ch", int'(valid_ch), 0);
        chk("R1 evt", int'(evt), 0);
        chk("R1 wd", int'(wd_evt), 0);
        chk("R1 overrun", int'(overrun), 0);

        // R4 round-robin rotation, R2 clipping at 12 bits
        last_ch = 4'd3; mode = 2'd0; acq_len = 8'd2; conv_len = 8'd2;
        for (int i = 0; i < NCH; i++) set_samp(i, 100 * (i + 1) + 7);
        set_samp(2, 5000);
        for (int n = 0; n < 5; n++) begin
            if (n == 4) set_samp(0, 999);
            clr();
            do_start();
            idle(8);
            chk("R4 one valid", vn, 1);
            chk("R4 channel", vch[0], n % 4);
            chk("R3 valid cycle", vcyc[0] - t0, 5);
            if (n == 0) chk("R4 value ch0", get_res(0), 107);
            if (n == 1) chk("R4 value ch1", get_res(1), 207);
            if (n == 2) chk("R2 clip 12b", get_res(2), 4095);
            if (n == 3) chk("R4 value ch3", get_res(3), 407);
            if (n < 3)  chk("R4 untouched next", get_res(n + 1), 0);
            if (n == 4) begin
                chk("R4 value ch0 again", get_res(0), 999);
                chk("R4 ch1 kept", get_res(1), 207);
            end
        end

        // R2 16-bit clipping and pass-through
        last_ch = 4'd0;
        res16 = 1'b1;
        set_samp(0, 70000); clr(); do_start(); idle(8);
        chk("R2 clip 16b", get_res(0), 65535);
        set_samp(0, 40000); clr(); do_start(); idle(8);
        chk("R2 pass 16b", get_res(0), 40000);
        res16 = 1'b0;
        set_samp(0, 4095); clr(); do_start(); idle(8);
        chk("R2 full 12b", get_res(0), 4095);
        set_samp(0, 4096); clr(); do_start(); idle(8);
        chk("R2 over 12b", get_res(0), 4095);

        // R5 parallel capture
        last_ch = 4'd3; mode = 2'd1;
        for (int i = 0; i < NCH; i++) set_samp(i, 1000 + 11 * i);
        clr(); do_start(); idle(8);
        chk("R5 one valid", vn, 1);
        chk("R5 channel", vch[0], 3);
        chk("R5 valid cycle", vcyc[0] - t0, 5);
        chk("R7 one event", en, 1);
        for (int i = 0; i < 4; i++) chk("R5 value", get_res(i), 1000 + 11 * i);
        chk("R5 inactive kept", get_res(4), 0);

        // R8 overrun
        mode = 2'd0; last_ch = 4'd0;
        chk("R8 no overrun yet", int'(overrun), 0);
        clr(); do_start(); idle(1); do_start(); idle(10);
        chk("R8 single valid", vn, 1);
        chk("R8 flag set", int'(overrun), 1);
        idle(3);
        chk("R8 flag sticky", int'(overrun), 1);

        // R7 event disabled
        irq_en = 1'b0;
        clr(); do_start(); idle(10);
        chk("R7 disabled", en, 0);
        irq_en = 1'b1;

        // R9 window watchdog
        wd_en = 1'b1; wd_lo = 16'd100; wd_hi = 16'd3000;
        begin
            int vals[6] = '{50, 2000, 3500, 9000, 100, 3000};
            int exps[6] = '{1, 0, 1, 1, 0, 0};
            for (int k = 0; k < 6; k++) begin
                set_samp(0, vals[k]); clr(); do_start(); idle(8);
                chk("R9 window", wn, exps[k]);
                if (wn == 1) chk("R9 same cycle", wcyc[0], vcyc[0]);
            end
        end
        wd_en = 1'b0;
        set_samp(0, 50); clr(); do_start(); idle(8);
        chk("R9 disabled", wn, 0);

        // R6 staggered mode with a measured period of 100
        mode = 2'd0; last_ch = 4'd0;
        do_start();
        s = t0;
        while (cyc < s + 99) @(negedge clk);
        mode = 2'd2; last_ch = 4'd3;
        for (int i = 0; i < NCH; i++) set_samp(i, 300 + 5 * i);
        clr();
        do_start();
        chk("R6 period", t0 - s, 100);
        idle(120);
        chk("R6 valid count", vn, 4);
        chk("R7 event count", en, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R6 launch time", vcyc[k] - t0, k * 25 + 5);
            chk("R6 channel", vch[k], k);
            chk("R6 value", get_res(k), 300 + 5 * k);
        end

        // R3 / R7 sweep of phase lengths, delay and event point
        mode = 2'd0; last_ch = 4'd0;
        for (int a = 1; a <= 4; a++)
            for (int c = 1; c <= 4; c++)
                for (int l = 0; l <= 3; l++)
                    for (int m = 0; m <= 1; m++) begin
                        acq_len = CW'(a); conv_len = CW'(c); lat = CW'(l); irq_at_conv = m[0];
                        clr(); do_start(); idle(a + c + l + 6);
                        chk("R3 sweep valid count", vn, 1);
                        chk("R3 sweep valid cycle", vcyc[0] - t0, a + c + 1);
                        chk("R7 sweep event count", en, 1);
                        chk("R7 sweep event cycle", ecyc[0] - t0, (m == 1 ? a + c + 1 : a + 1) + l);
                    end

        report();
        $finish;
    end

endmodule